// File: doc/BRIEF.md
# Two-Miss Branch Direction Predictor

This block predicts whether the next branch will be taken. It is a single-entry, four-state Moore machine. The state is two bits: a prediction bit and a record of the most recent resolved outcome. On a clock edge where the update strobe is high, the block takes in the resolved direction and moves to its next state. The prediction output flips only after two outcomes in a row disagree with it. When a weak state sees an outcome that goes against its prediction, it jumps straight to the opposite strong state. It does not step down one level at a time.

The prediction output comes only from the registered state, so the front end can read it at any time. The two-bit state is also driven out on a debug port, which lets a testbench follow every transition. A parameter picks how the next-state logic is built. One choice is a single merged equation. The other is a small circuit for each state, selected by a multiplexer driven by the current state. Both choices give the same behaviour.

Top module: `bp2_predictor`

## Requirements
- R1: While rst_ni is low, the state is 0 (strongly not taken) and pred_taken_o is 0. Reset is asynchronous and active low.
- R2: On a rising edge where upd_valid_i is 0, the state does not change.
- R3: Outcome encoding is 1 for taken and 0 for not taken. The state is {pred, last}, where pred is bit 1 and last is bit 0. After an edge where upd_valid_i is 1, the last bit equals the upd_taken_i value sampled at that edge.
- R4: On an accepted update, the pred bit takes the outcome value when the outcome equals the current last bit. Otherwise the pred bit keeps its value.
- R5: States are numbered {pred,last}: 3 is strongly taken, 2 is weakly taken, 1 is weakly not taken and 0 is strongly not taken. On not taken, the transitions are 0 to 0, 1 to 0, 2 to 0 and 3 to 2. On taken, they are 0 to 1, 1 to 3, 2 to 3 and 3 to 3.
- R6: pred_taken_o equals state bit 1. It has no combinational path from upd_valid_i or upd_taken_i.
- R7: The prediction reverses only when the outcome that goes against it is the second such outcome in a row, so the last bit already holds that same value. A single disagreeing outcome never changes pred_taken_o.
- R8: The merged-equation build (MUX_NEXT=0) and the per-state multiplexer build (MUX_NEXT=1) give identical state sequences for any input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. State updates on the rising edge. |
| rst_ni | input | 1 | Asynchronous active-low reset. |
| upd_valid_i | input | 1 | High when a resolved outcome is present. |
| upd_taken_i | input | 1 | Resolved direction: 1 means taken, 0 means not taken. |
| pred_taken_o | output | 1 | Prediction for the next branch: 1 means taken. |
| state_o | output | 2 | Debug copy of the state {pred, last}. |

## Verification
The bench builds two copies side by side, one with MUX_NEXT=0 and one with MUX_NEXT=1. This means both forms of the next-state logic run on every stimulus and are compared against the same model. Each of the four states is reached from reset and then hit with all four combinations of strobe and outcome. That covers every transition, every hold and every case where the prediction flips or stays. A long pseudo-random outcome stream with gaps in the strobe then checks the history rule over many runs of agreeing and disagreeing outcomes.

// File: rtl/bp2_pkg.sv
package bp2_pkg;
  localparam int STATE_W  = 2;
  localparam int PRED_BIT = 1;
  localparam int LAST_BIT = 0;
  localparam int N_STATES = 1 << STATE_W;

  typedef logic [STATE_W-1:0] bp2_state_t;

  localparam bp2_state_t ST_STRONG_NT = 2'd0;
  localparam bp2_state_t ST_WEAK_NT   = 2'd1;
  localparam bp2_state_t ST_WEAK_T    = 2'd2;
  localparam bp2_state_t ST_STRONG_T  = 2'd3;
endpackage

// File: rtl/bp2_next.sv
module bp2_next
  import bp2_pkg::*;
#(
  parameter bit MUX_NEXT = 1'b0
) (
  input  bp2_state_t state_i,
  input  logic       valid_i,
  input  logic       taken_i,
  output bp2_state_t state_o
);

  bp2_state_t upd_state;

  generate
    if (MUX_NEXT) begin : g_mux
      // one small next-state circuit per state, selected by current state
      bp2_state_t cand [N_STATES];
      for (genvar s = 0; s < N_STATES; s++) begin : g_cand
        localparam bp2_state_t SV = bp2_state_t'(s);
        always_comb begin
          cand[s][LAST_BIT] = taken_i;
          cand[s][PRED_BIT] = (taken_i == SV[LAST_BIT]) ? taken_i : SV[PRED_BIT];
        end
      end
      assign upd_state = cand[state_i];
    end else begin : g_eqn
      always_comb begin
        upd_state[LAST_BIT] = taken_i;
        upd_state[PRED_BIT] = (taken_i == state_i[LAST_BIT]) ? taken_i
                                                             : state_i[PRED_BIT];
      end
    end
  endgenerate

  assign state_o = valid_i ? upd_state : state_i;

endmodule

// File: rtl/bp2_state_reg.sv
module bp2_state_reg
  import bp2_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bp2_state_t d_i,
  output bp2_state_t q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= ST_STRONG_NT;
    else         q_o <= d_i;
  end

endmodule

// File: rtl/bp2_predictor.sv
module bp2_predictor
  import bp2_pkg::*;
#(
  parameter bit MUX_NEXT = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_valid_i,
  input  logic                upd_taken_i,
  output logic                pred_taken_o,
  output logic [STATE_W-1:0]  state_o
);

  bp2_state_t state_q, state_d;

  bp2_next #(.MUX_NEXT(MUX_NEXT)) u_next (
    .state_i (state_q),
    .valid_i (upd_valid_i),
    .taken_i (upd_taken_i),
    .state_o (state_d)
  );

  bp2_state_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  assign pred_taken_o = state_q[PRED_BIT];
  assign state_o      = state_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(state_q));

  p_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> state_q[LAST_BIT] == $past(upd_taken_i));

  p_pred_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i == state_q[LAST_BIT])
      |=> state_q[PRED_BIT] == $past(upd_taken_i));

  p_pred_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i != state_q[LAST_BIT]) |=> $stable(state_q[PRED_BIT]));

  p_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pred_taken_o) |-> $past(state_q[LAST_BIT]));

  p_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pred_taken_o) |-> !$past(state_q[LAST_BIT]));

endmodule

// File: tb/tb_bp2_predictor.sv
module tb_bp2_predictor;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic upd_valid = 1'b0;
  logic upd_taken = 1'b0;
  logic       pred_a, pred_b;
  logic [1:0] st_a, st_b;
  logic [1:0] model;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  bp2_predictor #(.MUX_NEXT(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .upd_valid_i(upd_valid), .upd_taken_i(upd_taken),
    .pred_taken_o(pred_a), .state_o(st_a));

  bp2_predictor #(.MUX_NEXT(1'b1)) dut_mux (
    .clk_i(clk), .rst_ni(rst_ni), .upd_valid_i(upd_valid), .upd_taken_i(upd_taken),
    .pred_taken_o(pred_b), .state_o(st_b));

  function automatic logic [1:0] nxt(logic [1:0] s, logic v, logic t);
    logic [1:0] r;
    if (!v) return s;
    r[0] = t;
    r[1] = (t == s[0]) ? t : s[1];
    return r;
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " dut state"}, st_a, model);
    chk({req, " dut_mux state"}, st_b, model);
    chk({req, " dut pred"}, {1'b0, pred_a}, {1'b0, model[1]});
    chk({req, " dut_mux pred"}, {1'b0, pred_b}, {1'b0, model[1]});
    chk("R8 builds agree", st_b, st_a);
  endtask

  task automatic step(logic v, logic t);
    @(negedge clk);
    upd_valid = v;
    upd_taken = t;
    @(posedge clk);
    model = nxt(model, v, t);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    upd_valid = 1'b0;
    #1;
    model = 2'd0;
    chk_all("R1 reset");
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic reach(logic [1:0] s);
    case (s)
      2'd1: step(1'b1, 1'b1);
      2'd2: begin step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0); end
      2'd3: begin step(1'b1, 1'b1); step(1'b1, 1'b1); end
      default: ;
    endcase
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [1:0]  t5 [4][2];
    model = 2'd0;
    // R5 transition table written out independently: [state][outcome]
    t5[0][0] = 2'd0; t5[0][1] = 2'd1;
    t5[1][0] = 2'd0; t5[1][1] = 2'd3;
    t5[2][0] = 2'd0; t5[2][1] = 2'd3;
    t5[3][0] = 2'd2; t5[3][1] = 2'd3;
    #(CLK_P/4);
    do_reset();

    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 2; v++) begin
        for (int t = 0; t < 2; t++) begin
          do_reset();
          reach(2'(s));
          chk("R5 reach", st_a, 2'(s));
          step(1'(v), 1'(t));
          chk_all(v ? "R3 R4 update" : "R2 hold");
          if (v) chk("R5 table", st_a, t5[s][t]);
          else   chk("R2 no change", st_a, 2'(s));
          if (v && (t != s[1]) && (t != s[0]))
            chk("R7 single miss keeps pred", {1'b0, pred_a}, {1'b0, 1'(s[1])});
        end
      end
    end

    // R6: input changes between edges do not reach the prediction
    do_reset();
    reach(2'd2);
    @(negedge clk);
    upd_valid = 1'b1; upd_taken = 1'b0;
    #1 chk("R6 no comb path", {1'b0, pred_a}, 2'b01);
    upd_taken = 1'b1;
    #1 chk("R6 no comb path", {1'b0, pred_b}, 2'b01);
    upd_valid = 1'b0;

    // R7: two misses flip from strong taken
    do_reset();
    reach(2'd3);
    step(1'b1, 1'b0);
    chk("R7 one miss", {1'b0, pred_a}, 2'b01);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    chk("R7 two misses", {1'b0, pred_a}, 2'b00);

    // long pseudo-random stream
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3] | lfsr[7], lfsr[0]);
      chk_all("R3 R4 R5 stream");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule